// File: doc/BRIEF.md
# Bank GPIO Register File with Masked-Write Aliases

This block holds the control state for one bank of 32 general-purpose pins, grouped as four ports of eight pins. Each port has three writable registers: a GPIO-enable (configuration) register, an output-enable register and an output-value register. It also has one read-only register that shows the synchronized pad level. Software reaches every register through a simple word-addressed bus. Writes take effect on the clock edge. Reads are combinational from the address.

Each writable register also appears a second time, at a fixed alias offset above its normal address. A write to the alias changes only the pins whose enable bit is set in the upper byte of the data word, so several agents can touch single pins without a read-modify-write. The block drives the pad output value and the pad drive enable. It brings the pad levels back through a two-flop synchronizer.

Pin index n of the bank maps to port n[4:3] and bit n[2:0]. That pin appears on pad bit n.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and after it is released with no write, every configuration, output-enable and output bit is 0, and pad_oe and pad_out are all 0.
- R2: A plain write to a configuration, output-enable or output register replaces all 8 bits with bus_wdata[7:0], whatever bus_wdata[15:8] holds. Every other register stays unchanged.
- R3: A write to an alias address sets each bit i, for which bus_wdata[8+i] is 1, to bus_wdata[i]. The bits whose enable is 0 keep their previous value.
- R4: The register word address is group + 4*port. The group offsets are: configuration 0x00, output-enable 0x10, output 0x20 and input 0x30. Bit b of port p corresponds to pad bit 8*p+b.
- R5: The alias of each configuration, output-enable and output register sits at its normal address plus MASK_OFS (default 0x800; 0x80 must also work). Reads of an alias address return 0.
- R6: The input registers are read-only. Writes to their addresses, or to input address plus MASK_OFS, change no register and no pad output.
- R7: A pad level reaches the input register readback after exactly two rising clock edges. After one edge the readback still shows the old level.
- R8: pad_oe bit n is 1 exactly when both the configuration bit and the output-enable bit of pin n are 1. pad_out bit n equals the output-register bit of pin n.
- R9: Every read returns the 8-bit register value in bus_rdata[7:0], with bus_rdata[31:8] equal to 0.
- R10: Writes to unmapped or misaligned addresses (bus_addr[1:0] not 0, offsets 0x40 and above outside the alias window) change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_wdata | input | 32 | Write data; [15:8] is the enable byte for alias writes |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables (1 = driven) |

## Verification
The checker verifies several rules on every clock edge:
- the upper read bits are zero;
- the pads are cleared after reset;
- the pad outputs cannot change in a cycle without a write;
- bits with a clear enable survive an alias write to port 0 output;
- clearing port 0 configuration releases its pads;
- input readback of port 0 lags the pad by two edges.

Some behaviour only the directed scenarios can show: the full address map across all four ports and both windows, read-back of alias addresses, rejection of misaligned and out-of-window addresses, and the exact edge at which a new pad level becomes visible. The bench shows these by comparing against its own register model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Number of ports in a bank; fixed by the two port-select address bits.
    localparam int NPORTS = 4;

    // Register groups, value equals address bits [5:4].
    typedef enum logic [1:0] {
        GRP_CFG = 2'd0,
        GRP_OE  = 2'd1,
        GRP_OUT = 2'd2,
        GRP_IN  = 2'd3
    } grp_e;

    // Decoded access.
    typedef struct packed {
        logic       hit;     // aligned and inside a mapped window
        logic       masked;  // inside the alias window
        grp_e       grp;
        logic [1:0] port;
    } dec_t;

endpackage

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MASK_OFS = 'h800
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(MASK_OFS);

    logic plain_win;
    logic alias_win;
    logic aligned;

    always_comb begin
        plain_win  = (addr[ADDR_W-1:6] == '0);
        alias_win  = (addr[ADDR_W-1:6] == OFS_V[ADDR_W-1:6]);
        aligned    = (addr[1:0] == 2'b00);
        dec.grp    = grp_e'(addr[5:4]);
        dec.port   = addr[3:2];
        dec.masked = alias_win;
        dec.hit    = aligned && (plain_win || (alias_win && dec.grp != GRP_IN));
    end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port #(
    parameter int PIN_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_cfg,
    input  logic               we_oe,
    input  logic               we_out,
    input  logic               masked,
    input  logic [2*PIN_W-1:0] wbits,
    output logic [PIN_W-1:0]   cfg_q,
    output logic [PIN_W-1:0]   oe_q,
    output logic [PIN_W-1:0]   out_q
);
    logic [PIN_W-1:0] en;
    logic [PIN_W-1:0] val;
    logic [PIN_W-1:0] cfg_n, oe_n, out_n;

    always_comb begin
        val   = wbits[PIN_W-1:0];
        en    = masked ? wbits[2*PIN_W-1:PIN_W] : '1;
        cfg_n = (cfg_q & ~en) | (val & en);
        oe_n  = (oe_q  & ~en) | (val & en);
        out_n = (out_q & ~en) | (val & en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            oe_q  <= '0;
            out_q <= '0;
        end else begin
            if (we_cfg) cfg_q <= cfg_n;
            if (we_oe)  oe_q  <= oe_n;
            if (we_out) out_q <= out_n;
        end
    end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W    = 8,
    parameter int ADDR_W   = 12,
    parameter int MASK_OFS = 'h800
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NPORTS*PIN_W-1:0] pad_in,
    output logic [NPORTS*PIN_W-1:0] pad_out,
    output logic [NPORTS*PIN_W-1:0] pad_oe
);
    localparam int PADS = NPORTS * PIN_W;

    dec_t dec;
    logic wr_hit;
    logic [NPORTS-1:0][PIN_W-1:0] cfg_q, oe_q, out_q;
    logic [PADS-1:0]  in_sync;
    logic [PIN_W-1:0] rd_port;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:2*PIN_W];

    gpio_bank_dec #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr_hit = bus_wr && dec.hit;

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_port
            logic sel;
            assign sel = wr_hit && (dec.port == 2'(p));
            gpio_bank_port #(.PIN_W(PIN_W)) u_port (
                .clk    (clk),
                .rst    (rst),
                .we_cfg (sel && dec.grp == GRP_CFG),
                .we_oe  (sel && dec.grp == GRP_OE),
                .we_out (sel && dec.grp == GRP_OUT),
                .masked (dec.masked),
                .wbits  (bus_wdata[2*PIN_W-1:0]),
                .cfg_q  (cfg_q[p]),
                .oe_q   (oe_q[p]),
                .out_q  (out_q[p])
            );
        end
    endgenerate

    gpio_bank_sync #(.WIDTH(PADS), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    always_comb begin
        rd_port = '0;
        if (dec.hit && !dec.masked) begin
            case (dec.grp)
                GRP_CFG: rd_port = cfg_q[dec.port];
                GRP_OE:  rd_port = oe_q[dec.port];
                GRP_OUT: rd_port = out_q[dec.port];
                default: rd_port = in_sync[dec.port*PIN_W +: PIN_W];
            endcase
        end
    end

    assign bus_rdata = 32'(rd_port);
    assign pad_out   = out_q;
    assign pad_oe    = cfg_q & oe_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int PIN_W    = 8,
    parameter int ADDR_W   = 12,
    parameter int MASK_OFS = 'h800,
    parameter int PADS     = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [2*PIN_W-1:0] wlo,
    input logic [31:0]        bus_rdata,
    input logic [PIN_W-1:0]   pin_in0,
    input logic [PADS-1:0]    pad_out,
    input logic [PADS-1:0]    pad_oe
);
    localparam logic [ADDR_W-1:0] A_OUT0_ALIAS = ADDR_W'(MASK_OFS + 'h20);
    localparam logic [ADDR_W-1:0] A_CFG0       = '0;
    localparam logic [ADDR_W-1:0] A_IN0        = ADDR_W'('h30);

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (pad_out == '0 && pad_oe == '0)) else $error("reset"); // R1

    AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:PIN_W] == '0) else $error("upper"); // R9

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && !$past(bus_wr)) |-> ($stable(pad_out) && $stable(pad_oe)))
        else $error("hold"); // R2

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && $past(bus_wr) && $past(bus_addr) == A_OUT0_ALIAS) |->
        ((pad_out[PIN_W-1:0] & ~$past(wlo[2*PIN_W-1:PIN_W])) ==
         ($past(pad_out[PIN_W-1:0]) & ~$past(wlo[2*PIN_W-1:PIN_W]))))
        else $error("mask keep"); // R3

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && $past(bus_wr) && $past(bus_addr) == A_OUT0_ALIAS) |->
        ((pad_out[PIN_W-1:0] & $past(wlo[2*PIN_W-1:PIN_W])) ==
         ($past(wlo[PIN_W-1:0]) & $past(wlo[2*PIN_W-1:PIN_W]))))
        else $error("mask set"); // R3

    AST_CFG_GATES_OE: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && $past(bus_wr) && $past(bus_addr) == A_CFG0 &&
         $past(wlo[PIN_W-1:0]) == '0) |-> (pad_oe[PIN_W-1:0] == '0))
        else $error("oe gate"); // R8

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && bus_addr == A_IN0) |->
        (bus_rdata[PIN_W-1:0] == $past(pin_in0, 2)))
        else $error("sync"); // R7
endmodule

bind gpio_bank gpio_bank_chk #(
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .PADS(PADS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wlo       (bus_wdata[2*PIN_W-1:0]),
    .bus_rdata (bus_rdata),
    .pin_in0   (pad_in[PIN_W-1:0]),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int AW   = 12;
    localparam int MOFS = 'h800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_cfg [4];
    logic [7:0] m_oe  [4];
    logic [7:0] m_out [4];

    always #2.5 clk = ~clk;

    gpio_bank #(.PIN_W(8), .ADDR_W(AW), .MASK_OFS(MOFS)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] pads_out();
        return {m_out[3], m_out[2], m_out[1], m_out[0]};
    endfunction
    function automatic logic [31:0] pads_oe();
        return {m_cfg[3] & m_oe[3], m_cfg[2] & m_oe[2], m_cfg[1] & m_oe[1], m_cfg[0] & m_oe[0]};
    endfunction

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            rd('h00 + 4*p, d); chk(req, d, {24'h0, m_cfg[p]});
            rd('h10 + 4*p, d); chk(req, d, {24'h0, m_oe[p]});
            rd('h20 + 4*p, d); chk(req, d, {24'h0, m_out[p]});
        end
        chk(req, pad_out, pads_out());
        chk(req, pad_oe, pads_oe());
    endtask

    task automatic t_reset();
        for (int p = 0; p < 4; p++) begin m_cfg[p] = '0; m_oe[p] = '0; m_out[p] = '0; end
        chk("R1", pad_out, 32'h0);
        chk("R1", pad_oe, 32'h0);
        check_all("R1");
    endtask

    task automatic t_plain();
        for (int p = 0; p < 4; p++) begin
            wr('h00 + 4*p, 32'hFFFF_0000 | (32'h11 * (p+1)));  m_cfg[p] = 8'(8'h11 * (p+1));
            wr('h10 + 4*p, 32'h0000_5A00 | (32'h0F << p));     m_oe[p]  = 8'(8'h0F << p);
            wr('h20 + 4*p, 32'hABCD_FF00 | (32'hA5 ^ p));      m_out[p] = 8'(8'hA5 ^ p);
        end
        check_all("R2 R4 R9");
        wr('h24, 32'h0000_FF3C); m_out[1] = 8'h3C;   // enable byte ignored
        check_all("R2");
    endtask

    task automatic t_masked();
        logic [31:0] d;
        wr(MOFS + 'h20, 32'h0000_F00F); m_out[0] = (m_out[0] & 8'h0F) | 8'h00;
        wr(MOFS + 'h2C, 32'h0000_0303); m_out[3] = (m_out[3] & 8'hFC) | 8'h03;
        wr(MOFS + 'h04, 32'h0000_8080); m_cfg[1] = m_cfg[1] | 8'h80;
        wr(MOFS + 'h18, 32'h0000_0100); m_oe[2]  = m_oe[2] & 8'hFE;
        wr(MOFS + 'h20, 32'h0000_00FF);            // zero enable: no change
        check_all("R3");
        rd(MOFS + 'h20, d); chk("R5 alias read", d, 32'h0);
        rd(MOFS + 'h04, d); chk("R5 alias read", d, 32'h0);
    endtask

    task automatic t_pads();
        wr('h00, 32'hF0); m_cfg[0] = 8'hF0;
        wr('h10, 32'h3C); m_oe[0]  = 8'h3C;
        chk("R8", pad_oe, pads_oe());
        wr('h00, 32'h00); m_cfg[0] = 8'h00;
        chk("R8", pad_oe, pads_oe());
        chk("R8", pad_out, pads_out());
    endtask

    task automatic t_input();
        logic [31:0] d;
        @(negedge clk); pad_in = 32'h0008_0000;        // pin 19 -> port 2 bit 3
        bus_addr = AW'('h38);
        @(negedge clk); #1 chk("R7 one edge", bus_rdata, 32'h0);
        @(negedge clk); #1 chk("R7 two edges", bus_rdata, 32'h08);
        pad_in = 32'h81C3_5A7E;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            rd('h30 + 4*p, d); chk("R4 R7", d, {24'h0, pad_in[8*p +: 8]});
        end
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr('h30, 32'h0000_FFFF);
        wr(MOFS + 'h34, 32'h0000_FFFF);
        rd('h30, d); chk("R6", d, 32'h7E);
        rd('h34, d); chk("R6", d, 32'h5A);
        check_all("R6");
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr('h01, 32'h0000_FFFF);
        wr('h22, 32'h0000_FFFF);
        wr('h40, 32'h0000_FFFF);
        wr('h100, 32'h0000_FFFF);
        wr(MOFS + 'h40, 32'h0000_FFFF);
        wr(MOFS + 'h21, 32'h0000_FFFF);
        check_all("R10");
        rd('h40, d);  chk("R10", d, 32'h0);
        rd('h21, d);  chk("R10", d, 32'h0);
        rd('h7FC, d); chk("R10", d, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();                 // checked while reset held
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_plain();
        t_masked();
        t_pads();
        t_input();
        t_readonly();
        t_unmapped();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule